// File: doc/BRIEF.md
# ROM Patch Correction Unit

The unit sits on the read path between a processor and a read-only program memory. It can replace individual bytes of that memory with correction bytes without changing the memory itself. Each of its channels holds the base of one aligned 8-byte window and a 64-bit word that carries one replacement byte per byte offset in that window. While correction is switched on, a read whose address falls in the window of an enabled channel returns the matching correction byte in the same cycle. Any other read returns the memory byte unchanged.

Software reaches the unit through a small register port. A control register moves through four legal codes, and these codes gate every change. Code 0x01 opens the channel registers for writing. Code 0x04 switches correction on and locks the channel registers. Switching correction off takes two steps: a clear code 0x0C, then 0x00. Only after that can the registers be opened again. Within a window, byte lanes follow little-endian order. When more than one enabled channel covers an address, the lowest-numbered channel supplies the byte.

Top module: `rom_patch_unit`

## Requirements
- R1: After reset the control register reads 0x00, every channel's address field and enable flag read 0, every data register reads 0, and no read is corrected.
- R2: In state 0x00 the only control write that takes effect is 0x01. A write of 0x04 or 0x0C is ignored.
- R3: A write to a channel address register or data register takes effect only while the control register holds 0x01. In any other state the register keeps its previous value.
- R4: From 0x01, control writes of 0x00, 0x01 and 0x04 take effect. In state 0x04 the only control write that takes effect is 0x0C.
- R5: In state 0x0C the only control write that takes effect is 0x00. No read is corrected in states 0x00, 0x01 or 0x0C.
- R6: A control write of any value other than 0x00, 0x01, 0x04 or 0x0C leaves the control register unchanged, whatever the state.
- R7: `cfg_sel[3:2]` selects the target register: 0 is control, 1 is address, 2 is data, 3 reads zero and ignores writes. `cfg_sel[1:0]` selects the channel. An address register keeps the base address in bits 19:0 and the enable flag in bit 20. Control reads back in bits 7:0. All unused read bits are zero.
- R8: In state 0x04, a read is corrected by an enabled channel when `rd_addr[19:3]` equals that channel's base bits 19:3. The returned byte is data bits `8*k+7:8*k`, where k = `rd_addr[2:0]`. This result appears combinationally, in the same cycle, and `patch_hit` is high.
- R9: A channel whose enable flag is 0 never corrects a read, even in state 0x04.
- R10: When several enabled channels match the same read, the byte comes from the lowest-numbered one.
- R11: When no channel corrects a read, `cpu_rdata` equals `rom_rdata` and `patch_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select: kind in bits 3:2, channel in bits 1:0 |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Read-back of the selected register |
| rd_addr | input | 20 | Byte address of the current memory read |
| rom_rdata | input | 8 | Byte returned by the program memory |
| cpu_rdata | output | 8 | Byte delivered to the processor |
| patch_hit | output | 1 | High when the current read is corrected |

## Verification
The embedded properties assume that `cfg_we`, `cfg_sel` and `cfg_wdata` are stable around each rising edge. They also assume that `rd_addr` and `rom_rdata` settle within the cycle, because the correction path is purely combinational. The bench changes every input only on the falling edge and holds it through the next rising edge. It waits for the internal reset release before its first register write. Stimulus deliberately includes illegal control codes and writes made in every locked state. The locking properties are therefore exercised, not merely left vacuous.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

  typedef enum logic [7:0] {
    CTRL_IDLE   = 8'h00,
    CTRL_WREN   = 8'h01,
    CTRL_ACTIVE = 8'h04,
    CTRL_CLEAR  = 8'h0C
  } ctrl_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } sel_kind_e;

endpackage

// File: rtl/rpu_ctrl_fsm.sv
module rpu_ctrl_fsm
  import rpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output ctrl_e      ctrl_q,
  output logic       unlocked,
  output logic       active
);

  ctrl_e ctrl_nxt;

  // next-state: only listed transitions are honoured
  always_comb begin
    ctrl_nxt = ctrl_q;
    unique case (ctrl_q)
      CTRL_IDLE: begin
        if (ctrl_wdata == CTRL_WREN) ctrl_nxt = CTRL_WREN;
      end
      CTRL_WREN: begin
        case (ctrl_wdata)
          CTRL_IDLE:   ctrl_nxt = CTRL_IDLE;
          CTRL_WREN:   ctrl_nxt = CTRL_WREN;
          CTRL_ACTIVE: ctrl_nxt = CTRL_ACTIVE;
          default:     ctrl_nxt = ctrl_q;
        endcase
      end
      CTRL_ACTIVE: begin
        if (ctrl_wdata == CTRL_CLEAR) ctrl_nxt = CTRL_CLEAR;
      end
      CTRL_CLEAR: begin
        if (ctrl_wdata == CTRL_IDLE) ctrl_nxt = CTRL_IDLE;
      end
      default: ctrl_nxt = CTRL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_IDLE;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_nxt;
    end
  end

  assign unlocked = (ctrl_q == CTRL_WREN);
  assign active   = (ctrl_q == CTRL_ACTIVE);

  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == CTRL_IDLE) |=> (ctrl_q == CTRL_IDLE || ctrl_q == CTRL_WREN));

  assert_active_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == CTRL_ACTIVE) |=> (ctrl_q == CTRL_ACTIVE || ctrl_q == CTRL_CLEAR));

  assert_clear_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == CTRL_CLEAR) |=> (ctrl_q == CTRL_CLEAR || ctrl_q == CTRL_IDLE));

  assert_bad_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata != 8'h00 && ctrl_wdata != 8'h01 &&
     ctrl_wdata != 8'h04 && ctrl_wdata != 8'h0C) |=> $stable(ctrl_q));

endmodule

// File: rtl/rpu_channel.sv
module rpu_channel #(
  parameter int ADDR_W    = 20,
  parameter int BYTE_W    = 8,
  parameter int LANE_BITS = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   unlocked,
  input  logic                                   active,
  input  logic                                   addr_we,
  input  logic                                   data_we,
  input  logic [(BYTE_W << LANE_BITS)-1:0]       wdata,
  input  logic [ADDR_W-1:0]                      rd_addr,
  output logic [ADDR_W-1:0]                      base_q,
  output logic                                   en_q,
  output logic [(BYTE_W << LANE_BITS)-1:0]       data_q,
  output logic                                   hit,
  output logic [BYTE_W-1:0]                      hit_byte
);

  localparam int LANES  = 1 << LANE_BITS;
  localparam int DATA_W = BYTE_W * LANES;

  logic              ld_base;
  logic              ld_data;
  logic [ADDR_W-1:0] base_nxt;
  logic              en_nxt;
  logic [DATA_W-1:0] data_nxt;
  logic [BYTE_W-1:0] lane [LANES];

  // clock enables: writes land only while unlocked
  assign ld_base  = addr_we & unlocked;
  assign ld_data  = data_we & unlocked;
  assign base_nxt = wdata[ADDR_W-1:0];
  assign en_nxt   = wdata[ADDR_W];
  assign data_nxt = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else if (ld_base) begin
      base_q <= base_nxt;
      en_q   <= en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (ld_data) begin
      data_q <= data_nxt;
    end
  end

  // little-endian lane split
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = data_q[g*BYTE_W +: BYTE_W];
  end

  assign hit = active & en_q &
               (rd_addr[ADDR_W-1:LANE_BITS] == base_q[ADDR_W-1:LANE_BITS]);
  assign hit_byte = lane[rd_addr[LANE_BITS-1:0]];

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(base_q) && $stable(en_q) && $stable(data_q)));

  assert_flag_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !hit);

endmodule

// File: rtl/rpu_select.sv
module rpu_select #(
  parameter int CHANNELS = 4,
  parameter int BYTE_W   = 8
) (
  input  logic [CHANNELS-1:0]             hit,
  input  logic [CHANNELS-1:0][BYTE_W-1:0] ch_byte,
  input  logic [BYTE_W-1:0]               rom_byte,
  output logic [BYTE_W-1:0]               out_byte,
  output logic [CHANNELS-1:0]             grant,
  output logic                            any_hit
);

  // descending scan so the lowest matching channel is applied last
  always_comb begin
    grant    = '0;
    out_byte = rom_byte;
    for (int i = CHANNELS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        out_byte = ch_byte[i];
      end
    end
  end

  assign any_hit = |hit;

endmodule

// File: rtl/rom_patch_unit.sv
module rom_patch_unit
  import rpu_pkg::*;
#(
  parameter int CHANNELS  = 4,
  parameter int ADDR_W    = 20,
  parameter int BYTE_W    = 8,
  parameter int LANE_BITS = 3
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         cfg_we,
  input  logic [((CHANNELS > 1) ? $clog2(CHANNELS) : 1)+1:0] cfg_sel,
  input  logic [(BYTE_W << LANE_BITS)-1:0]             cfg_wdata,
  output logic [(BYTE_W << LANE_BITS)-1:0]             cfg_rdata,
  input  logic [ADDR_W-1:0]                            rd_addr,
  input  logic [BYTE_W-1:0]                            rom_rdata,
  output logic [BYTE_W-1:0]                            cpu_rdata,
  output logic                                         patch_hit
);

  localparam int CH_W   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam int SEL_W  = CH_W + 2;
  localparam int DATA_W = BYTE_W << LANE_BITS;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // register select decode
  sel_kind_e       sel_kind;
  logic [CH_W-1:0] sel_ch;
  logic            ctrl_we;

  assign sel_kind = sel_kind_e'(cfg_sel[SEL_W-1 -: 2]);
  assign sel_ch   = cfg_sel[CH_W-1:0];
  assign ctrl_we  = cfg_we && (sel_kind == SEL_CTRL);

  ctrl_e ctrl_q;
  logic  unlocked;
  logic  active;

  rpu_ctrl_fsm u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (cfg_wdata[7:0]),
    .ctrl_q     (ctrl_q),
    .unlocked   (unlocked),
    .active     (active)
  );

  logic [CHANNELS-1:0]             ch_hit;
  logic [CHANNELS-1:0][BYTE_W-1:0] ch_byte;
  logic [ADDR_W-1:0]               ch_base [CHANNELS];
  logic [CHANNELS-1:0]             ch_en;
  logic [DATA_W-1:0]               ch_data [CHANNELS];
  logic [CHANNELS-1:0]             ch_addr_we;
  logic [CHANNELS-1:0]             ch_data_we;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    assign ch_addr_we[g] = cfg_we && (sel_kind == SEL_ADDR) && (sel_ch == CH_W'(g));
    assign ch_data_we[g] = cfg_we && (sel_kind == SEL_DATA) && (sel_ch == CH_W'(g));

    rpu_channel #(
      .ADDR_W    (ADDR_W),
      .BYTE_W    (BYTE_W),
      .LANE_BITS (LANE_BITS)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .unlocked (unlocked),
      .active   (active),
      .addr_we  (ch_addr_we[g]),
      .data_we  (ch_data_we[g]),
      .wdata    (cfg_wdata),
      .rd_addr  (rd_addr),
      .base_q   (ch_base[g]),
      .en_q     (ch_en[g]),
      .data_q   (ch_data[g]),
      .hit      (ch_hit[g]),
      .hit_byte (ch_byte[g])
    );
  end

  logic [CHANNELS-1:0] grant;

  rpu_select #(
    .CHANNELS (CHANNELS),
    .BYTE_W   (BYTE_W)
  ) u_sel (
    .hit      (ch_hit),
    .ch_byte  (ch_byte),
    .rom_byte (rom_rdata),
    .out_byte (cpu_rdata),
    .grant    (grant),
    .any_hit  (patch_hit)
  );

  // read-back mux
  always_comb begin
    cfg_rdata = '0;
    unique case (sel_kind)
      SEL_CTRL: cfg_rdata[7:0] = ctrl_q;
      SEL_ADDR: begin
        if (int'(sel_ch) < CHANNELS) begin
          cfg_rdata[ADDR_W-1:0] = ch_base[sel_ch];
          cfg_rdata[ADDR_W]     = ch_en[sel_ch];
        end
      end
      SEL_DATA: begin
        if (int'(sel_ch) < CHANNELS) cfg_rdata = ch_data[sel_ch];
      end
      default: cfg_rdata = '0;
    endcase
  end

  assert_hit_needs_active_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    patch_hit |-> (ctrl_q == CTRL_ACTIVE));

  assert_single_winner_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant) && (patch_hit == (grant != '0)));

  assert_passthru_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !patch_hit |-> (cpu_rdata == rom_rdata));

endmodule

// File: tb/rom_patch_unit_bench.sv
`timescale 1ns/1ps
module rom_patch_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [63:0] cfg_wdata;
  logic [63:0] cfg_rdata;
  logic [19:0] rd_addr;
  logic [7:0]  rom_rdata;
  logic [7:0]  cpu_rdata;
  logic        patch_hit;

  rom_patch_unit u_rom_patch_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .rd_addr   (rd_addr),
    .rom_rdata (rom_rdata),
    .cpu_rdata (cpu_rdata),
    .patch_hit (patch_hit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done     = 0;
  string cur_req  = "R1";

  // behavioural reference state
  logic [7:0]  m_ctrl;
  logic [19:0] m_base [4];
  logic        m_en   [4];
  logic [63:0] m_data [4];

  task automatic model_reset();
    m_ctrl = 8'h00;
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0;
      m_en[i]   = 1'b0;
      m_data[i] = '0;
    end
  endtask

  function automatic logic [63:0] exp_rdata(input logic [3:0] sel);
    int ch = int'(sel[1:0]);
    case (sel[3:2])
      2'd0:    return {56'd0, m_ctrl};
      2'd1:    return {43'd0, m_en[ch], m_base[ch]};
      2'd2:    return m_data[ch];
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [8:0] exp_read(input logic [19:0] a, input logic [7:0] rom);
    if (m_ctrl == 8'h04) begin
      for (int ch = 0; ch < 4; ch++) begin
        if (m_en[ch] && (a[19:3] == m_base[ch][19:3])) begin
          int k = int'(a[2:0]);
          return {1'b1, m_data[ch][8*k +: 8]};
        end
      end
    end
    return {1'b0, rom};
  endfunction

  task automatic model_write(input logic [3:0] sel, input logic [63:0] w);
    int ch = int'(sel[1:0]);
    case (sel[3:2])
      2'd0: begin
        case (m_ctrl)
          8'h00: if (w[7:0] == 8'h01) m_ctrl = 8'h01;
          8'h01: if (w[7:0] == 8'h00 || w[7:0] == 8'h01 || w[7:0] == 8'h04) m_ctrl = w[7:0];
          8'h04: if (w[7:0] == 8'h0C) m_ctrl = 8'h0C;
          8'h0C: if (w[7:0] == 8'h00) m_ctrl = 8'h00;
          default: m_ctrl = m_ctrl;
        endcase
      end
      2'd1: if (m_ctrl == 8'h01) begin
        m_base[ch] = w[19:0];
        m_en[ch]   = w[20];
      end
      2'd2: if (m_ctrl == 8'h01) m_data[ch] = w;
      default: ;
    endcase
  endtask

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // one clock: drive on the falling edge, compare, then commit at the rising edge
  task automatic cyc(input logic we, input logic [3:0] sel, input logic [63:0] w,
                     input logic [19:0] a, input logic [7:0] rom);
    logic [8:0] er;
    cfg_we    = we;
    cfg_sel   = sel;
    cfg_wdata = w;
    rd_addr   = a;
    rom_rdata = rom;
    #1;
    er = exp_read(a, rom);
    check("cfg_rdata", cfg_rdata, exp_rdata(sel));
    check("cpu_rdata", {56'd0, cpu_rdata}, {56'd0, er[7:0]});
    check("patch_hit", {63'd0, patch_hit}, {63'd0, er[8]});
    @(posedge clk);
    if (we) model_write(sel, w);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] sel, input logic [63:0] w);
    cyc(1'b1, sel, w, 20'h0, 8'h00);
  endtask

  task automatic rd(input logic [3:0] sel);
    cyc(1'b0, sel, 64'd0, 20'h0, 8'h00);
  endtask

  task automatic fetch(input logic [19:0] a);
    cyc(1'b0, 4'h0, 64'd0, a, 8'($urandom));
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; rd_addr = '0; rom_rdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    cur_req = "R1";
    for (int s = 0; s < 16; s++) rd(4'(s));
    fetch(20'h00000);

    cur_req = "R3";
    wr(4'h4, 64'h0000_0000_0011_2340);
    wr(4'h8, 64'hDEAD_BEEF_0000_1111);
    rd(4'h4); rd(4'h8);

    cur_req = "R2";
    wr(4'h0, 64'h04); rd(4'h0);
    wr(4'h0, 64'h0C); rd(4'h0);
    cur_req = "R6";
    wr(4'h0, 64'h55); rd(4'h0);
    cur_req = "R2";
    wr(4'h0, 64'h01); rd(4'h0);

    cur_req = "R7";
    wr(4'h4, 64'h0000_0000_0011_2340);
    wr(4'h5, 64'h0000_0000_0011_2345);
    wr(4'h6, 64'h0000_0000_0000_0010);
    wr(4'h7, 64'h0000_0000_001F_FFF8);
    wr(4'h8, 64'h8877_6655_4433_2211);
    wr(4'h9, 64'hF7F6_F5F4_F3F2_F1F0);
    wr(4'hA, 64'hA7A6_A5A4_A3A2_A1A0);
    wr(4'hB, 64'hC7C6_C5C4_C3C2_C1C0);
    wr(4'hC, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int s = 0; s < 16; s++) rd(4'(s));

    cur_req = "R6";
    wr(4'h0, 64'h77); rd(4'h0);
    cur_req = "R5";
    fetch(20'h12341);
    cur_req = "R4";
    wr(4'h0, 64'h04); rd(4'h0);
    wr(4'h0, 64'h00); rd(4'h0);
    wr(4'h0, 64'h01); rd(4'h0);
    cur_req = "R3";
    wr(4'h4, 64'h0000_0000_0000_0000);
    wr(4'h8, 64'h0);
    rd(4'h4); rd(4'h8);

    cur_req = "R8";
    for (int k = 0; k < 8; k++) fetch(20'h12340 + 20'(k));
    for (int k = 0; k < 8; k++) fetch(20'hFFFF8 + 20'(k));
    cur_req = "R10";
    fetch(20'h12342); fetch(20'h12347);
    cur_req = "R9";
    for (int k = 0; k < 8; k++) fetch(20'h00010 + 20'(k));
    cur_req = "R11";
    fetch(20'h12348); fetch(20'h1233F); fetch(20'h7FFF8); fetch(20'hFFFF0);

    cur_req = "R5";
    wr(4'h0, 64'h0C); rd(4'h0);
    fetch(20'h12343);
    wr(4'h0, 64'h04); rd(4'h0);
    wr(4'h0, 64'h01); rd(4'h0);
    wr(4'h0, 64'h00); rd(4'h0);

    cur_req = "R10";
    wr(4'h0, 64'h01);
    wr(4'h4, 64'h0000_0000_0001_2340);
    wr(4'h0, 64'h04);
    for (int k = 0; k < 8; k++) fetch(20'h12340 + 20'(k));

    cur_req = "R8";
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  codes [5] = '{8'h00, 8'h01, 8'h04, 8'h0C, 8'h3A};
      logic [19:0] bases [4] = '{20'h12340, 20'hFFFF8, 20'h00010, 20'h55550};
      logic [3:0]  sel  = 4'($urandom);
      logic [63:0] w    = {$urandom, $urandom};
      logic        we   = ($urandom % 3) == 0;
      if (sel[3:2] == 2'd0) w = {56'd0, codes[$urandom % 5]};
      if (sel[3:2] == 2'd1) w = {43'd0, 1'($urandom), bases[$urandom % 4] | 20'($urandom % 8)};
      cyc(we, sel, w, bases[$urandom % 4] + 20'($urandom % 12), 8'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog %s: actual=running expected=finished", cur_req);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule